// File: doc/BRIEF.md
# Trap Entry Privilege State Stacker

This block holds the machine-level and supervisor-level status fields and cause registers of a processor hart. When an interrupt is taken, it also saves the memory-access modifier bits in high cause bits that would otherwise be zero, and then clears the live copies. This lets a handler that runs with interrupts enabled be preempted without losing the modified-privilege state. For machine-level interrupts the saved bits are the privilege-override enable and the previous-privilege field. For supervisor-level interrupts they are the execute-readable and user-page-access permissions.

The matching return strobe copies the saved bits back, but only when the cause register marks an interrupt. A return from a synchronous exception leaves the live bits alone. The block also computes the privilege that data loads and stores use, and whether each permission bit is in force for the current access.

The surrounding core decodes instructions, delegates traps and walks page tables. It supplies the current privilege, a trap strobe carrying the target level and cause code, the two return strobes and a write port for the status fields.

Top module: `priv_stack_unit`

## Requirements
- R1: After reset all status bits are 0, the machine previous-privilege field is U, both cause registers are 0, and the effective privilege equals the current privilege. Privilege encoding: U=2'b00, S=2'b01, M=2'b11.
- R2: A machine-level interrupt (trap_irq_i=1, trap_to_m_i=1) writes mcause with bit 31 set, bit 26 set to the old override enable, bits 25:24 set to the old previous-privilege field, and the cause code in the low bits. In the same cycle it clears the override enable and loads the previous-privilege field with the current privilege.
- R3: A supervisor-level interrupt writes scause with bit 31 set, bit 25 set to the execute-readable bit, bit 24 set to the user-access bit, and the code in the low bits. It clears both live bits and sets spp_o when the current privilege is not U.
- R4: A synchronous exception writes bit 31 as 0, bits 26:24 as 0 and the code in the low bits into the target cause register. It leaves the override enable, execute-readable and user-access bits unchanged.
- R5: A machine return with mcause bit 31 set restores the override enable from bit 26 and the previous-privilege field from bits 25:24. The restored field takes priority over the usual reset of that field to U. With mcause bit 31 clear, the field becomes U and the override enable is not restored.
- R6: A supervisor return with scause bit 31 set restores the execute-readable bit from bit 25 and the user-access bit from bit 24. With bit 31 clear, both bits are unchanged. Every supervisor return clears the override enable and sets spp_o to 0.
- R7: A machine return whose target (the previous-privilege field before the return) is below M leaves the override enable at 0, even after a restore.
- R8: On trap entry the target level's previous-interrupt-enable takes the old interrupt enable, and the interrupt enable is cleared. On return the interrupt enable takes the previous value and the previous-interrupt-enable is set to 1.
- R9: eff_priv_o equals the previous-privilege field when the override enable is 1 and the current privilege is M. Otherwise it equals the current privilege.
- R10: mxr_act_o is the execute-readable bit when the effective privilege is below M, and 0 otherwise. sum_act_o is the user-access bit when the effective privilege is S, and 0 otherwise.
- R11: When events coincide in one cycle, a trap wins over a machine return, which wins over a supervisor return, which wins over a status write. A status write of 2'b10 to the previous-privilege field stores U.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cur_priv_i | input | 2 | Current privilege of the hart |
| trap_valid_i | input | 1 | A trap is taken this cycle |
| trap_irq_i | input | 1 | Trap is an interrupt (1) or an exception (0) |
| trap_to_m_i | input | 1 | Trap target is machine level (1) or supervisor level (0) |
| trap_code_i | input | CODE_W | Cause code |
| mret_i | input | 1 | Machine return strobe |
| sret_i | input | 1 | Supervisor return strobe |
| stat_we_i | input | 1 | Status field write enable |
| stat_mprv_i | input | 1 | Write value: privilege override enable |
| stat_mxr_i | input | 1 | Write value: execute-readable permission |
| stat_sum_i | input | 1 | Write value: user-page-access permission |
| stat_mpp_i | input | 2 | Write value: machine previous privilege |
| stat_spp_i | input | 1 | Write value: supervisor previous privilege |
| stat_mie_i | input | 1 | Write value: machine interrupt enable |
| stat_sie_i | input | 1 | Write value: supervisor interrupt enable |
| mprv_o | output | 1 | Privilege override enable |
| mxr_o | output | 1 | Execute-readable permission |
| sum_o | output | 1 | User-page-access permission |
| mpp_o | output | 2 | Machine previous privilege |
| spp_o | output | 1 | Supervisor previous privilege |
| mie_o | output | 1 | Machine interrupt enable |
| mpie_o | output | 1 | Machine previous interrupt enable |
| sie_o | output | 1 | Supervisor interrupt enable |
| spie_o | output | 1 | Supervisor previous interrupt enable |
| mcause_o | output | XLEN | Machine cause register |
| scause_o | output | XLEN | Supervisor cause register |
| eff_priv_o | output | 2 | Privilege used for data loads and stores |
| mxr_act_o | output | 1 | Execute-readable permission in force |
| sum_act_o | output | 1 | User-access permission in force |

## Verification
The central case is a machine interrupt taken from M with the override enable set and the previous-privilege field at S. The handler's return must bring back both values. A design that let the usual reset to U win would leave loads on the wrong privilege. A design that cleared the override enable on every return would lose it. Exception entries and returns follow interrupt ones, so a design that restores without testing cause bit 31 replays stale bits. A return to U is checked to clear the override enable after its restore. Coincident trap and return strobes, the illegal 2'b10 write, and the permission-active outputs at each effective privilege are driven directly.

// File: rtl/priv_stack_pkg.sv
package priv_stack_pkg;
  typedef logic [1:0] priv_t;

  localparam priv_t PRIV_U = 2'b00;
  localparam priv_t PRIV_S = 2'b01;
  localparam priv_t PRIV_M = 2'b11;

  // Save slots in the cause word, decoded by the return path
  localparam int unsigned MPRV_SAVE_BIT = 26;
  localparam int unsigned MPP_SAVE_LO   = 24;
  localparam int unsigned MXR_SAVE_BIT  = 25;
  localparam int unsigned SUM_SAVE_BIT  = 24;

  function automatic priv_t legal_priv(input priv_t p);
    return (p == 2'b10) ? PRIV_U : p;
  endfunction
endpackage

// File: rtl/m_priv_stack.sv
module m_priv_stack
  import priv_stack_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  priv_t             cur_priv_i,
  input  logic              trap_i,
  input  logic              irq_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              mret_i,
  input  logic              sret_i,
  input  logic              wr_i,
  input  logic              wr_mprv_i,
  input  priv_t             wr_mpp_i,
  input  logic              wr_mie_i,
  output logic              mprv_o,
  output priv_t             mpp_o,
  output logic              mie_o,
  output logic              mpie_o,
  output logic [XLEN-1:0]   mcause_o
);
  localparam int unsigned IRQ_BIT = XLEN - 1;

  logic            mprv_q, mie_q, mpie_q;
  priv_t           mpp_q;
  logic [XLEN-1:0] mcause_q, cause_d;
  logic            saved_irq;

  assign saved_irq = mcause_q[IRQ_BIT];

  always_comb begin
    cause_d = '0;
    cause_d[IRQ_BIT] = irq_i;
    cause_d[CODE_W-1:0] = code_i;
    if (irq_i) begin
      cause_d[MPRV_SAVE_BIT]      = mprv_q;
      cause_d[MPP_SAVE_LO +: 2]   = mpp_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mprv_q   <= 1'b0;
      mpp_q    <= PRIV_U;
      mie_q    <= 1'b0;
      mpie_q   <= 1'b0;
      mcause_q <= '0;
    end else if (trap_i) begin
      mcause_q <= cause_d;
      mpie_q   <= mie_q;
      mie_q    <= 1'b0;
      mpp_q    <= legal_priv(cur_priv_i);
      if (irq_i) mprv_q <= 1'b0;
    end else if (mret_i) begin
      mie_q  <= mpie_q;
      mpie_q <= 1'b1;
      mpp_q  <= saved_irq ? mcause_q[MPP_SAVE_LO +: 2] : PRIV_U;
      // target below M wins over the restore
      if (mpp_q != PRIV_M)  mprv_q <= 1'b0;
      else if (saved_irq)   mprv_q <= mcause_q[MPRV_SAVE_BIT];
    end else if (sret_i) begin
      mprv_q <= 1'b0;
    end else if (wr_i) begin
      mprv_q <= wr_mprv_i;
      mpp_q  <= legal_priv(wr_mpp_i);
      mie_q  <= wr_mie_i;
    end
  end

  assign mprv_o   = mprv_q;
  assign mpp_o    = mpp_q;
  assign mie_o    = mie_q;
  assign mpie_o   = mpie_q;
  assign mcause_o = mcause_q;

  p_irq_save_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i && irq_i |=> !mprv_q && mcause_q[MPRV_SAVE_BIT] == $past(mprv_q)
                        && mcause_q[MPP_SAVE_LO +: 2] == $past(mpp_q));
  p_exc_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i && !irq_i |=> mprv_q == $past(mprv_q) && mcause_q[26:24] == 3'b000);
  p_ret_restore_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mret_i && saved_irq |=> mpp_q == $past(mcause_q[MPP_SAVE_LO +: 2]));
  p_ret_plain_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mret_i && !saved_irq |=> mpp_q == PRIV_U);
  p_ret_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mret_i && mpp_q != PRIV_M |=> !mprv_q);
  p_ie_stack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> !mie_q && mpie_q == $past(mie_q));
  p_mpp_legal_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mpp_q != 2'b10);
endmodule

// File: rtl/s_priv_stack.sv
module s_priv_stack
  import priv_stack_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  priv_t             cur_priv_i,
  input  logic              trap_i,
  input  logic              irq_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              sret_i,
  input  logic              wr_i,
  input  logic              wr_mxr_i,
  input  logic              wr_sum_i,
  input  logic              wr_spp_i,
  input  logic              wr_sie_i,
  output logic              mxr_o,
  output logic              sum_o,
  output logic              spp_o,
  output logic              sie_o,
  output logic              spie_o,
  output logic [XLEN-1:0]   scause_o
);
  localparam int unsigned IRQ_BIT = XLEN - 1;

  logic            mxr_q, sum_q, spp_q, sie_q, spie_q;
  logic [XLEN-1:0] scause_q, cause_d;
  logic            saved_irq;

  assign saved_irq = scause_q[IRQ_BIT];

  always_comb begin
    cause_d = '0;
    cause_d[IRQ_BIT] = irq_i;
    cause_d[CODE_W-1:0] = code_i;
    if (irq_i) begin
      cause_d[MXR_SAVE_BIT] = mxr_q;
      cause_d[SUM_SAVE_BIT] = sum_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mxr_q    <= 1'b0;
      sum_q    <= 1'b0;
      spp_q    <= 1'b0;
      sie_q    <= 1'b0;
      spie_q   <= 1'b0;
      scause_q <= '0;
    end else if (trap_i) begin
      scause_q <= cause_d;
      spie_q   <= sie_q;
      sie_q    <= 1'b0;
      spp_q    <= (cur_priv_i != PRIV_U);
      if (irq_i) begin
        mxr_q <= 1'b0;
        sum_q <= 1'b0;
      end
    end else if (sret_i) begin
      sie_q  <= spie_q;
      spie_q <= 1'b1;
      spp_q  <= 1'b0;
      if (saved_irq) begin
        mxr_q <= scause_q[MXR_SAVE_BIT];
        sum_q <= scause_q[SUM_SAVE_BIT];
      end
    end else if (wr_i) begin
      mxr_q <= wr_mxr_i;
      sum_q <= wr_sum_i;
      spp_q <= wr_spp_i;
      sie_q <= wr_sie_i;
    end
  end

  assign mxr_o    = mxr_q;
  assign sum_o    = sum_q;
  assign spp_o    = spp_q;
  assign sie_o    = sie_q;
  assign spie_o   = spie_q;
  assign scause_o = scause_q;

  p_irq_save_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i && irq_i |=> !mxr_q && !sum_q && scause_q[MXR_SAVE_BIT] == $past(mxr_q)
                        && scause_q[SUM_SAVE_BIT] == $past(sum_q));
  p_exc_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i && !irq_i |=> mxr_q == $past(mxr_q) && sum_q == $past(sum_q));
  p_ret_restore_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sret_i && saved_irq |=> mxr_q == $past(scause_q[MXR_SAVE_BIT])
                            && sum_q == $past(scause_q[SUM_SAVE_BIT]));
  p_ret_plain_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sret_i && !saved_irq |=> $stable(mxr_q) && $stable(sum_q));
  p_ie_ret_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sret_i |=> spie_q && sie_q == $past(spie_q));
endmodule

// File: rtl/eff_priv_calc.sv
module eff_priv_calc
  import priv_stack_pkg::*;
(
  input  priv_t cur_priv_i,
  input  logic  mprv_i,
  input  priv_t mpp_i,
  input  logic  mxr_i,
  input  logic  sum_i,
  output priv_t eff_priv_o,
  output logic  mxr_act_o,
  output logic  sum_act_o
);
  priv_t eff;

  assign eff        = (mprv_i && cur_priv_i == PRIV_M) ? mpp_i : cur_priv_i;
  assign eff_priv_o = eff;
  assign mxr_act_o  = mxr_i && (eff != PRIV_M);
  assign sum_act_o  = sum_i && (eff == PRIV_S);
endmodule

// File: rtl/priv_stack_unit.sv
module priv_stack_unit
  import priv_stack_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cur_priv_i,
  input  logic              trap_valid_i,
  input  logic              trap_irq_i,
  input  logic              trap_to_m_i,
  input  logic [CODE_W-1:0] trap_code_i,
  input  logic              mret_i,
  input  logic              sret_i,
  input  logic              stat_we_i,
  input  logic              stat_mprv_i,
  input  logic              stat_mxr_i,
  input  logic              stat_sum_i,
  input  logic [1:0]        stat_mpp_i,
  input  logic              stat_spp_i,
  input  logic              stat_mie_i,
  input  logic              stat_sie_i,
  output logic              mprv_o,
  output logic              mxr_o,
  output logic              sum_o,
  output logic [1:0]        mpp_o,
  output logic              spp_o,
  output logic              mie_o,
  output logic              mpie_o,
  output logic              sie_o,
  output logic              spie_o,
  output logic [XLEN-1:0]   mcause_o,
  output logic [XLEN-1:0]   scause_o,
  output logic [1:0]        eff_priv_o,
  output logic              mxr_act_o,
  output logic              sum_act_o
);
  // Event priority: trap > mret > sret > status write
  logic ev_mtrap, ev_strap, ev_mret, ev_sret, ev_wr;
  logic mprv, mxr, sum;
  priv_t mpp;

  assign ev_mtrap = trap_valid_i & trap_to_m_i;
  assign ev_strap = trap_valid_i & ~trap_to_m_i;
  assign ev_mret  = mret_i & ~trap_valid_i;
  assign ev_sret  = sret_i & ~trap_valid_i & ~mret_i;
  assign ev_wr    = stat_we_i & ~(trap_valid_i | mret_i | sret_i);

  m_priv_stack #(.XLEN(XLEN), .CODE_W(CODE_W)) i_m_stack (
    .clk_i, .rst_ni, .cur_priv_i,
    .trap_i(ev_mtrap), .irq_i(trap_irq_i), .code_i(trap_code_i),
    .mret_i(ev_mret), .sret_i(ev_sret),
    .wr_i(ev_wr), .wr_mprv_i(stat_mprv_i), .wr_mpp_i(stat_mpp_i), .wr_mie_i(stat_mie_i),
    .mprv_o(mprv), .mpp_o(mpp), .mie_o, .mpie_o, .mcause_o
  );

  s_priv_stack #(.XLEN(XLEN), .CODE_W(CODE_W)) i_s_stack (
    .clk_i, .rst_ni, .cur_priv_i,
    .trap_i(ev_strap), .irq_i(trap_irq_i), .code_i(trap_code_i),
    .sret_i(ev_sret),
    .wr_i(ev_wr), .wr_mxr_i(stat_mxr_i), .wr_sum_i(stat_sum_i),
    .wr_spp_i(stat_spp_i), .wr_sie_i(stat_sie_i),
    .mxr_o(mxr), .sum_o(sum), .spp_o, .sie_o, .spie_o, .scause_o
  );

  eff_priv_calc i_eff (
    .cur_priv_i, .mprv_i(mprv), .mpp_i(mpp), .mxr_i(mxr), .sum_i(sum),
    .eff_priv_o, .mxr_act_o, .sum_act_o
  );

  assign mprv_o = mprv;
  assign mpp_o  = mpp;
  assign mxr_o  = mxr;
  assign sum_o  = sum;

  p_trap_over_ret_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i && trap_to_m_i && mret_i |=> !mie_o);
  p_sret_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sret_i && !trap_valid_i && !mret_i |=> !mprv_o);
endmodule

// File: tb/test_priv_stack_unit.sv
`timescale 1ns/1ps
module test_priv_stack_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cp;
  logic        tv, tirq, tom, mr, sr, we;
  logic [7:0]  code, arg;
  logic        mprv, mxr, sum, spp, mie, mpie, sie, spie, mxa, sua;
  logic [1:0]  mpp, eff;
  logic [31:0] mcause, scause;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  priv_stack_unit i_priv_stack_unit (
    .clk_i(clk), .rst_ni(rst_n), .cur_priv_i(cp),
    .trap_valid_i(tv), .trap_irq_i(tirq), .trap_to_m_i(tom), .trap_code_i(code),
    .mret_i(mr), .sret_i(sr), .stat_we_i(we),
    .stat_mprv_i(arg[7]), .stat_mxr_i(arg[6]), .stat_sum_i(arg[5]),
    .stat_mpp_i(arg[4:3]), .stat_spp_i(arg[2]), .stat_mie_i(arg[1]), .stat_sie_i(arg[0]),
    .mprv_o(mprv), .mxr_o(mxr), .sum_o(sum), .mpp_o(mpp), .spp_o(spp),
    .mie_o(mie), .mpie_o(mpie), .sie_o(sie), .spie_o(spie),
    .mcause_o(mcause), .scause_o(scause),
    .eff_priv_o(eff), .mxr_act_o(mxa), .sum_act_o(sua)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // arg: [7]mprv [6]mxr [5]sum [4:3]mpp [2]spp [1]mie [0]sie
  task automatic step(input logic t, input logic irq, input logic to_m, input logic [7:0] c,
                      input logic m_ret, input logic s_ret, input logic w,
                      input logic [7:0] a, input logic [1:0] p);
    @(negedge clk);
    tv = t; tirq = irq; tom = to_m; code = c; mr = m_ret; sr = s_ret; we = w; arg = a; cp = p;
    @(negedge clk);
    tv = 1'b0; mr = 1'b0; sr = 1'b0; we = 1'b0;
  endtask

  // {op, cur_priv, arg, expected {mprv, mpp, mxr, sum, eff}}
  // op: 0 write, 1 M irq, 2 M exc, 3 S irq, 4 S exc, 5 mret, 6 sret
  localparam logic [19:0] VEC [13] = '{
    {3'd0, 2'b11, 8'b1000_1010, 7'b1_01_0_0_01},  // M, override on, prev S
    {3'd1, 2'b11, 8'h00,        7'b0_11_0_0_11},  // nested M irq: R2
    {3'd5, 2'b11, 8'h00,        7'b1_01_0_0_01},  // return restores: R5
    {3'd2, 2'b11, 8'h00,        7'b1_11_0_0_11},  // exception keeps: R4
    {3'd5, 2'b11, 8'h00,        7'b1_00_0_0_00},  // no restore, prev U
    {3'd0, 2'b01, 8'b0110_0001, 7'b0_00_1_1_01},
    {3'd3, 2'b01, 8'h00,        7'b0_00_0_0_01},  // S irq: R3
    {3'd6, 2'b01, 8'h00,        7'b0_00_1_1_01},  // restore: R6
    {3'd4, 2'b00, 8'h00,        7'b0_00_1_1_00},  // S exc: R4
    {3'd6, 2'b01, 8'h00,        7'b0_00_1_1_01},  // no restore: R6
    {3'd0, 2'b11, 8'b1110_0000, 7'b1_00_1_1_00},
    {3'd1, 2'b00, 8'h00,        7'b0_00_1_1_00},
    {3'd5, 2'b11, 8'h00,        7'b0_00_1_1_11}   // return to U clears: R7
  };

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cp = 2'b11; tv = 0; tirq = 0; tom = 0; mr = 0; sr = 0; we = 0;
    code = 8'h00; arg = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 status", {mprv, mxr, sum, mpp, spp, mie, mpie, sie, spie}, 10'b0);
    chk("R1 mcause", mcause, 32'h0);
    chk("R1 scause", scause, 32'h0);
    chk("R1 eff", eff, 2'b11);
    rst_n = 1'b1;

    for (int i = 0; i < 13; i++) begin
      logic [2:0] op;
      logic [1:0] p;
      logic [7:0] a;
      logic [6:0] e;
      string tag;
      {op, p, a, e} = VEC[i];
      case (op)
        3'd0: begin step(0, 0, 0, 8'h00, 0, 0, 1, a, p); tag = "R9 write"; end
        3'd1: begin step(1, 1, 1, 8'h03, 0, 0, 0, a, p); tag = "R2 m-irq"; end
        3'd2: begin step(1, 0, 1, 8'h02, 0, 0, 0, a, p); tag = "R4 m-exc"; end
        3'd3: begin step(1, 1, 0, 8'h05, 0, 0, 0, a, p); tag = "R3 s-irq"; end
        3'd4: begin step(1, 0, 0, 8'h0d, 0, 0, 0, a, p); tag = "R4 s-exc"; end
        3'd5: begin step(0, 0, 0, 8'h00, 1, 0, 0, a, p); tag = "R5 mret"; end
        default: begin step(0, 0, 0, 8'h00, 0, 1, 0, a, p); tag = "R6 sret"; end
      endcase
      chk($sformatf("%s vec %0d", tag, i), {25'b0, mprv, mpp, mxr, sum, eff}, {25'b0, e});
    end
    chk("R7 mprv after return to U", mprv, 1'b0);

    // R2 full word: irq from S with override on, prev S, code 7
    step(0, 0, 0, 8'h00, 0, 0, 1, 8'b1000_1000, 2'b11);
    step(1, 1, 1, 8'h07, 0, 0, 0, 8'h00, 2'b01);
    chk("R2 mcause word", mcause, 32'h8500_0007);
    chk("R2 mpp from cur", mpp, 2'b01);

    // R4 exceptions leave save bits zero and modifiers alone
    step(0, 0, 0, 8'h00, 0, 0, 1, 8'b1100_1000, 2'b11);
    step(1, 0, 1, 8'h02, 0, 0, 0, 8'h00, 2'b11);
    chk("R4 mcause word", mcause, 32'h0000_0002);
    chk("R4 mprv kept", mprv, 1'b1);
    step(1, 0, 0, 8'h0d, 0, 0, 0, 8'h00, 2'b01);
    chk("R4 scause word", scause, 32'h0000_000d);
    chk("R4 mxr kept", mxr, 1'b1);

    // R3 full word and spp from U
    step(0, 0, 0, 8'h00, 0, 0, 1, 8'b0100_0100, 2'b00);
    step(1, 1, 0, 8'h05, 0, 0, 0, 8'h00, 2'b00);
    chk("R3 scause word", scause, 32'h8200_0005);
    chk("R3 spp", spp, 1'b0);

    // R8 interrupt-enable stacking
    step(0, 0, 0, 8'h00, 0, 0, 1, 8'b0000_0011, 2'b11);
    step(1, 1, 1, 8'h03, 0, 0, 0, 8'h00, 2'b11);
    chk("R8 m entry", {mie, mpie}, 2'b01);
    step(0, 0, 0, 8'h00, 1, 0, 0, 8'h00, 2'b11);
    chk("R8 m return", {mie, mpie}, 2'b11);
    step(1, 1, 0, 8'h01, 0, 0, 0, 8'h00, 2'b01);
    chk("R8 s entry", {sie, spie}, 2'b01);
    step(0, 0, 0, 8'h00, 0, 1, 0, 8'h00, 2'b01);
    chk("R8 s return", {sie, spie, spp}, 3'b110);

    // R11 trap wins over coincident mret; illegal mpp write
    step(0, 0, 0, 8'h00, 0, 0, 1, 8'b0000_1010, 2'b11);
    step(1, 0, 1, 8'h04, 1, 0, 0, 8'h00, 2'b11);
    chk("R11 trap over mret", {mie, mpp, mcause[7:0]}, {1'b0, 2'b11, 8'h04});
    step(0, 0, 0, 8'h00, 0, 1, 1, 8'b1001_0000, 2'b11);
    chk("R11 sret over write", mprv, 1'b0);
    step(0, 0, 0, 8'h00, 0, 0, 1, 8'b0001_0000, 2'b11);
    chk("R11 mpp 10 to U", mpp, 2'b00);

    // R10 permission-active outputs
    step(0, 0, 0, 8'h00, 0, 0, 1, 8'b1110_1000, 2'b11);
    chk("R10 M via S", {eff, mxa, sua}, 4'b01_1_1);
    step(0, 0, 0, 8'h00, 0, 0, 1, 8'b1111_1000, 2'b11);
    chk("R10 M via M", {eff, mxa, sua}, 4'b11_0_0);
    step(0, 0, 0, 8'h00, 0, 0, 1, 8'b0110_0000, 2'b00);
    chk("R10 U mode", {eff, mxa, sua}, 4'b00_1_0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule